// File: doc/BRIEF.md
# Host-Driven Memory Cycle Controller

This block lets a host processor run one memory access at a time over an asynchronous four-phase request/acknowledge pair. The host loads byte-lane data registers, sets a direction, a bus-width bit and two lane-valid bits in a control register, and then writes the control register again with its request bit set. The block raises its request pin and waits for the memory side to pull the acknowledge low. It then drops the request and waits for the acknowledge to return high. A sticky status bit reports the end of the cycle.

During a read cycle, the bytes on the enabled lanes are captured into the lane registers when the acknowledge is seen low, so the host can read them once the cycle is done. When direct memory access traffic is active, a request is refused: no cycle starts and an error status bit is set. The acknowledge input passes through a synchronizer, so it may change at any time relative to the clock.

Top module: `hmc_ctrl`

## Requirements
- R1: After reset, `mem_breq` is 0, `mem_write` is 0, `mem_lane_n` is 2'b11, `mem_dout` is 0, and all four registers read 0.
- R2: A write to the control register (address 2) with bit 7 set, made while idle and with `dma_active` low, raises `mem_breq` after that clock edge. Control bit 7 reads back 1 while the cycle runs. A control write with bit 7 clear starts nothing.
- R3: `mem_breq` stays high until `mem_back_n` low has passed a SYNC_STAGES-flop synchronizer. It falls SYNC_STAGES+1 clock edges after `mem_back_n` falls.
- R4: SYNC_STAGES+1 edges after `mem_back_n` returns high, status bit 7 (address 3) becomes 1 and control bit 7 clears. Status bit 7 stays 1 through later writes whose bit 7 is clear.
- R5: Any control write with bit 7 set clears status bit 7 at that edge.
- R6: During a cycle, `mem_write` equals control bit 6 (1 = write). On a write cycle, `mem_dout[15:8]` carries the high lane register (address 1) and `mem_dout[7:0]` carries the low lane register (address 0), each only if its lane is enabled; otherwise the lane is 0. Outside write cycles, `mem_dout` is 0.
- R7: The lane enables are {control bit 1, control bit 0} (high, low) when control bit 2 (wide) is 1, and low lane only when it is 0. `mem_lane_n` is their active-low form during a cycle and 2'b11 after a cycle ends.
- R8: On a read cycle, each enabled lane register loads its byte of `mem_din`. Disabled lanes keep their value.
- R9: A request written while `dma_active` is high starts no cycle, sets status bit 0 and clears status bit 7. The next accepted request clears status bit 0.
- R10: All register writes made while a cycle is in progress are ignored, including a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_active | input | 1 | High while direct memory access traffic owns the memory |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 low lane, 1 high lane, 2 control, 3 status |
| reg_wdata | input | LANE_W | Register write data |
| reg_rdata | output | LANE_W | Register read data (combinational) |
| mem_breq | output | 1 | Memory cycle request, active high |
| mem_back_n | input | 1 | Memory acknowledge, active low, asynchronous |
| mem_write | output | 1 | Direction of the running cycle, 1 = write |
| mem_lane_n | output | 2 | Active-low lane valid, bit 1 high lane, bit 0 low lane |
| mem_dout | output | 2*LANE_W | Write data toward memory |
| mem_din | input | 2*LANE_W | Read data from memory |

## Verification
The request pin rises one edge after the accepting control write. It falls on the third edge after the acknowledge falls: two synchronizer stages and then the state register. Completion appears in status, and the request bit clears, on the third edge after the acknowledge rises. The bench drives every input at a falling edge and counts rising edges from that point. It checks each result at the falling edge just after the edge where the result is due, and also one edge earlier to confirm the result has not arrived early. Captured read data is compared after completion against lane masks the bench computes on its own.

// File: rtl/hmc_pkg.sv
package hmc_pkg;

  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_ASSERT  = 2'd1,
    HS_RELEASE = 2'd2
  } hs_state_e;

  // register addresses
  localparam logic [1:0] A_LO   = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  // control / status bit positions
  localparam int B_REQ  = 7;
  localparam int B_WR   = 6;
  localparam int B_WIDE = 2;
  localparam int B_HV   = 1;
  localparam int B_LV   = 0;
  localparam int B_DONE = 7;
  localparam int B_ERR  = 0;

  // active-high lane enables {high, low}
  function automatic logic [1:0] lane_sel(input logic wide, input logic hv, input logic lv);
    return wide ? {hv, lv} : 2'b01;
  endfunction

endpackage

// File: rtl/hmc_sync.sv
module hmc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hmc_hs_fsm.sv
module hmc_hs_fsm
  import hmc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack_sync_n,
  output logic breq,
  output logic busy,
  output logic capture,
  output logic done
);
  hs_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      HS_IDLE:    if (start)       state_nx = HS_ASSERT;
      HS_ASSERT:  if (!ack_sync_n) state_nx = HS_RELEASE;
      HS_RELEASE: if (ack_sync_n)  state_nx = HS_IDLE;
      default:                     state_nx = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= HS_IDLE;
    else        state <= state_nx;
  end

  assign breq    = (state == HS_ASSERT);
  assign busy    = (state != HS_IDLE);
  assign capture = (state == HS_ASSERT) && !ack_sync_n;
  assign done    = (state == HS_RELEASE) && ack_sync_n;
endmodule

// File: rtl/hmc_regs.sv
module hmc_regs
  import hmc_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int BUS_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_active,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [LANE_W-1:0] reg_wdata,
  output logic [LANE_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              capture,
  input  logic              done,
  input  logic [BUS_W-1:0]  mem_din,
  output logic              start,
  output logic              refuse,
  output logic              wr_dir,
  output logic [1:0]        lane_en,
  output logic              done_flag,
  output logic [LANE_W-1:0] lo_q,
  output logic [LANE_W-1:0] hi_q
);
  logic [LANE_W-1:0] ctrl_q;
  logic              req_q;
  logic              err_q;
  logic              ctrl_wr;
  logic              req_wr;

  assign ctrl_wr = reg_we && !busy && (reg_addr == A_CTRL);
  assign req_wr  = ctrl_wr && reg_wdata[B_REQ];
  assign start   = req_wr && !dma_active;
  assign refuse  = req_wr && dma_active;

  assign wr_dir  = ctrl_q[B_WR];
  assign lane_en = lane_sel(ctrl_q[B_WIDE], ctrl_q[B_HV], ctrl_q[B_LV]);

  // lane data: host writes when idle, memory captures on reads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (reg_we && !busy) begin
      if (reg_addr == A_LO) lo_q <= reg_wdata;
      if (reg_addr == A_HI) hi_q <= reg_wdata;
    end else if (capture && !wr_dir) begin
      if (lane_en[0]) lo_q <= mem_din[LANE_W-1:0];
      if (lane_en[1]) hi_q <= mem_din[BUS_W-1:LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      done_flag <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (start)     req_q <= 1'b1;
      else if (done) req_q <= 1'b0;

      if (req_wr)    done_flag <= 1'b0;
      else if (done) done_flag <= 1'b1;

      if (refuse)     err_q <= 1'b1;
      else if (start) err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_LO:   reg_rdata = lo_q;
      A_HI:   reg_rdata = hi_q;
      A_CTRL: begin
        reg_rdata        = ctrl_q;
        reg_rdata[B_REQ] = req_q;
      end
      default: begin
        reg_rdata[B_DONE] = done_flag;
        reg_rdata[B_ERR]  = err_q;
      end
    endcase
  end
endmodule

// File: rtl/hmc_ctrl.sv
module hmc_ctrl
  import hmc_pkg::*;
#(
  parameter int LANE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int BUS_W      = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_active,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [LANE_W-1:0] reg_wdata,
  output logic [LANE_W-1:0] reg_rdata,
  output logic              mem_breq,
  input  logic              mem_back_n,
  output logic              mem_write,
  output logic [1:0]        mem_lane_n,
  output logic [BUS_W-1:0]  mem_dout,
  input  logic [BUS_W-1:0]  mem_din
);
  // named internal events
  logic              ack_sync_n;
  logic              start_evt;
  logic              refuse_evt;
  logic              capture_evt;
  logic              done_evt;
  logic              busy;
  logic              wr_dir;
  logic [1:0]        lane_en;
  logic              done_flag;
  logic [LANE_W-1:0] lo_q;
  logic [LANE_W-1:0] hi_q;

  hmc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mem_back_n),
    .q     (ack_sync_n)
  );

  hmc_hs_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_evt),
    .ack_sync_n (ack_sync_n),
    .breq       (mem_breq),
    .busy       (busy),
    .capture    (capture_evt),
    .done       (done_evt)
  );

  hmc_regs #(.LANE_W(LANE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_active (dma_active),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .capture    (capture_evt),
    .done       (done_evt),
    .mem_din    (mem_din),
    .start      (start_evt),
    .refuse     (refuse_evt),
    .wr_dir     (wr_dir),
    .lane_en    (lane_en),
    .done_flag  (done_flag),
    .lo_q       (lo_q),
    .hi_q       (hi_q)
  );

  assign mem_write  = busy && wr_dir;
  assign mem_lane_n = busy ? ~lane_en : 2'b11;

  always_comb begin
    mem_dout = '0;
    if (busy && wr_dir) begin
      if (lane_en[0]) mem_dout[LANE_W-1:0]     = lo_q;
      if (lane_en[1]) mem_dout[BUS_W-1:LANE_W] = hi_q;
    end
  end
endmodule

// File: rtl/hmc_ctrl_chk.sv
module hmc_ctrl_chk #(
  parameter int LANE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dma_active,
  input logic              mem_breq,
  input logic [1:0]        mem_lane_n,
  input logic              ack_sync_n,
  input logic              refuse_evt,
  input logic              capture_evt,
  input logic              done_evt,
  input logic              busy,
  input logic              done_flag,
  input logic [LANE_W-1:0] lo_q,
  input logic [LANE_W-1:0] hi_q
);
  // R2
  req_rise_no_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_breq) |-> !$past(dma_active));

  // R9
  refused_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_evt |=> !mem_breq);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_breq && ack_sync_n |=> mem_breq);

  // R3
  req_fall_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_breq) |-> !$past(ack_sync_n));

  // R4
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> done_flag);

  // R4
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(done_evt));

  // R7
  lanes_idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> mem_lane_n == 2'b11);

  // R10
  lanes_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !capture_evt |=> $stable(lo_q) && $stable(hi_q));
endmodule

bind hmc_ctrl hmc_ctrl_chk #(.LANE_W(LANE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dma_active  (dma_active),
  .mem_breq    (mem_breq),
  .mem_lane_n  (mem_lane_n),
  .ack_sync_n  (ack_sync_n),
  .refuse_evt  (refuse_evt),
  .capture_evt (capture_evt),
  .done_evt    (done_evt),
  .busy        (busy),
  .done_flag   (done_flag),
  .lo_q        (lo_q),
  .hi_q        (hi_q)
);

// File: tb/test_hmc_ctrl.sv
module test_hmc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_active = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        mem_breq;
  logic        mem_back_n = 1'b1;
  logic        mem_write;
  logic [1:0]  mem_lane_n;
  logic [15:0] mem_dout;
  logic [15:0] mem_din = 16'd0;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hmc_ctrl i_hmc_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_active (dma_active),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .mem_breq   (mem_breq),
    .mem_back_n (mem_back_n),
    .mem_write  (mem_write),
    .mem_lane_n (mem_lane_n),
    .mem_dout   (mem_dout),
    .mem_din    (mem_din)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  // called at the falling edge just after the accepting edge
  task automatic run_hs(input logic [15:0] din);
    logic [7:0] v;
    chk("R2 request pin raised", {15'd0, mem_breq}, 16'd1);
    @(negedge clk);
    chk("R3 request held without ack", {15'd0, mem_breq}, 16'd1);
    mem_din = din; mem_back_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R3 request held during sync", {15'd0, mem_breq}, 16'd1);
    @(negedge clk);
    chk("R3 request dropped after sync", {15'd0, mem_breq}, 16'd0);
    mem_back_n = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(2'd3, v);
    chk("R4 complete not early", {15'd0, v[7]}, 16'd0);
    @(negedge clk);
    rd(2'd3, v);
    chk("R4 complete set", {15'd0, v[7]}, 16'd1);
    rd(2'd2, v);
    chk("R4 request bit cleared", {15'd0, v[7]}, 16'd0);
    chk("R7 lanes idle after cycle", {14'd0, mem_lane_n}, 16'h3);
    mem_din = 16'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1 breq at reset", {15'd0, mem_breq}, 16'd0);
    chk("R1 write at reset", {15'd0, mem_write}, 16'd0);
    chk("R1 lanes at reset", {14'd0, mem_lane_n}, 16'h3);
    chk("R1 dout at reset", mem_dout, 16'd0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 register at reset", {8'd0, v}, 16'd0);
    end
    rst_n = 1'b1;

    // sweep: width, direction, high-valid, low-valid
    for (int cfg = 0; cfg < 16; cfg++) begin
      logic       wide, dir, hv, lv;
      logic [1:0] en;
      logic [7:0] dlo, dhi, ctrl;
      logic [15:0] din, exp_dout;
      wide = cfg[3]; dir = cfg[2]; hv = cfg[1]; lv = cfg[0];
      dlo = 8'(cfg * 37 + 5);
      dhi = 8'(cfg * 91 + 200);
      din = {8'(cfg * 13 + 64), 8'(cfg * 29 + 128)};
      en  = wide ? {hv, lv} : 2'b01;
      ctrl = {1'b0, dir, 3'b000, wide, hv, lv};
      wr(2'd0, dlo);
      wr(2'd1, dhi);
      wr(2'd2, ctrl);
      chk("R2 no request bit starts nothing", {15'd0, mem_breq}, 16'd0);
      rd(2'd3, v);
      chk("R4 complete stays sticky", {15'd0, v[7]}, (cfg > 0) ? 16'd1 : 16'd0);
      wr(2'd2, ctrl | 8'h80);
      rd(2'd3, v);
      chk("R5 request clears complete", {15'd0, v[7]}, 16'd0);
      rd(2'd2, v);
      chk("R2 request bit reads busy", {8'd0, v}, {8'd0, ctrl | 8'h80});
      chk("R7 lane valid pins", {14'd0, mem_lane_n}, {14'd0, ~en});
      chk("R6 direction pin", {15'd0, mem_write}, {15'd0, dir});
      exp_dout = dir ? {en[1] ? dhi : 8'd0, en[0] ? dlo : 8'd0} : 16'd0;
      chk("R6 write data lanes", mem_dout, exp_dout);
      run_hs(din);
      rd(2'd0, v);
      chk("R8 low lane after cycle", {8'd0, v}, {8'd0, (!dir && en[0]) ? din[7:0] : dlo});
      rd(2'd1, v);
      chk("R8 high lane after cycle", {8'd0, v}, {8'd0, (!dir && en[1]) ? din[15:8] : dhi});
    end

    // refusal while DMA owns memory
    @(negedge clk);
    dma_active = 1'b1;
    wr(2'd2, 8'h87);
    chk("R9 refused request no breq", {15'd0, mem_breq}, 16'd0);
    repeat (3) @(negedge clk);
    chk("R9 still no breq", {15'd0, mem_breq}, 16'd0);
    rd(2'd3, v);
    chk("R9 error set, complete cleared", {8'd0, v}, 16'h01);
    dma_active = 1'b0;
    wr(2'd2, 8'h87);
    rd(2'd3, v);
    chk("R9 error cleared on accepted request", {8'd0, v}, 16'h00);
    run_hs(16'hA55A);
    rd(2'd0, v);
    chk("R8 wide read low", {8'd0, v}, 16'h5A);
    rd(2'd1, v);
    chk("R8 wide read high", {8'd0, v}, 16'hA5);

    // writes during a cycle are ignored
    wr(2'd0, 8'h3C);
    wr(2'd2, 8'hC1);
    chk("R6 narrow write data", mem_dout, 16'h003C);
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h87);
    run_hs(16'h0000);
    rd(2'd0, v);
    chk("R10 lane write ignored while busy", {8'd0, v}, 16'h3C);
    rd(2'd2, v);
    chk("R10 control write ignored while busy", {8'd0, v}, 16'h41);
    repeat (4) @(negedge clk);
    chk("R10 no second cycle", {15'd0, mem_breq}, 16'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule